// File: doc/BRIEF.md
# Dual-Path Divider Configuration Loader

This block holds the settings for the two dividers of a clock synthesizer. The first is a 9-bit feedback divide value. The second is a 2-bit output divide code. The settings can come from parallel pins or from a three-wire serial port, which has a load strobe, a serial clock and serial data. Each path has two behaviours. While its enable is active, the path is transparent. On a specific edge of its strobe, the path latches its value.

All pins are treated as synchronous to the block clock. Edges on them are found by comparing each pin with its value at the previous clock edge. Every output is registered, so an output reflects the pins as sampled at the previous rising clock edge.

The block also does three other jobs:
- It decodes the output divide code into a one-hot divide ratio.
- It flags a feedback value outside the usable oscillator window. The value is not clamped.
- It has a master reset input that only drops the output enable and leaves the stored settings alone.

Top module: `divcfg_loader`

## Requirements
- R1: While `serStrobe` is low and `parLoadN` is low, one clock after a sample `divM`/`divN` equal the sampled `parM`/`parN` and `testSel` is 0.
- R2: A rising `parLoadN` captures `parM`/`parN` into the held setting. While `parLoadN` stays high and `serStrobe` stays low, later pin changes do not alter the outputs.
- R3: The serial word is 13 bits, shifted MSB first: test-select bits 12..11, output code bits 10..9, feedback value bits 8..0. One bit from `serData` is taken on each rising `serClk` while `serStrobe` is low, so the last bit shifted lands in bit 0.
- R4: While `serStrobe` is high, the outputs show the shift register fields. `serClk` and `serData` have no effect on the shift register.
- R5: A falling `serStrobe` latches the shift register into the held setting. The held setting is kept after the fall.
- R6: A serial latch replaces any earlier parallel capture. A parallel capture keeps the previously held test-select bits.
- R7: While `masterRst` is high, `outEnable` is 0 one clock later and 1 one clock after it goes low. The divider outputs are unaffected.
- R8: `divRatio` is one-hot, and its value is the divide ratio: code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R9: `mOutOfRange` is 1 exactly when the presented `divM` is below 10 or above 28.
- R10: After `rstN` goes low: `divM` is 10, `divN` is 0, `testSel` is 0, `outEnable` is 0 and `divRatio` is 1.
- R11: A high `serStrobe` takes priority over a low `parLoadN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterRst | input | 1 | Forces the output enable low; stored settings kept |
| parLoadN | input | 1 | Parallel load enable, active low |
| parM | input | 9 | Parallel feedback divide value |
| parN | input | 2 | Parallel output divide code |
| serStrobe | input | 1 | Serial load strobe |
| serClk | input | 1 | Serial shift clock (sampled) |
| serData | input | 1 | Serial data bit |
| divM | output | 9 | Feedback divide value presented downstream |
| divN | output | 2 | Output divide code presented downstream |
| divRatio | output | 4 | Decoded output divide ratio |
| testSel | output | 2 | Test-select bits |
| outEnable | output | 1 | Output enable |
| mOutOfRange | output | 1 | Feedback value outside 10..28 |

## Verification
The bench drives the block through each of its modes, and each pattern separates one pair of behaviours:
- **Parallel transparency and capture.** Pin changes are made after a capture, so a design that keeps passing the pins through is caught.
- **Serial shifting.** A word with unlike field values is shifted in and then read back with the strobe high. This exposes bit-order and field-position errors. Toggling the serial clock and data while the strobe is high separates a guarded shift register from a free-running one.
- **Precedence.** A parallel capture followed by a serial latch shows which source wins. A low parallel enable under a high strobe checks the priority of the two paths.
- **Limits.** Feedback values 9, 10, 28, 29 and a large value probe both edges of the range flag. All four output codes check the ratio decode.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int SER_W   = T_W + N_W + M_W;
  localparam int RATIO_W = 1 << N_W;

  // Field order matches the serial shift order, MSB first.
  typedef struct packed {
    logic [T_W-1:0] test;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfgWord_t;

  typedef enum logic [1:0] {
    MODE_HELD    = 2'd0,
    MODE_PARLIVE = 2'd1,
    MODE_SERLIVE = 2'd2
  } srcMode_t;

  typedef struct packed {
    logic     shiftEn;
    logic     serLatch;
    logic     parCapture;
    srcMode_t mode;
  } ctrlStrobes_t;
endpackage

// File: rtl/divcfg_ctrl.sv
module divcfg_ctrl
  import divcfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         parLoadN,
  input  logic         serStrobe,
  input  logic         serClk,
  output ctrlStrobes_t strobes
);
  logic prevParLoadN;
  logic prevSerStrobe;
  logic prevSerClk;

  // Previous-sample registers; reset values match idle pin levels.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevParLoadN  <= 1'b1;
      prevSerStrobe <= 1'b0;
      prevSerClk    <= 1'b0;
    end else begin
      prevParLoadN  <= parLoadN;
      prevSerStrobe <= serStrobe;
      prevSerClk    <= serClk;
    end
  end

  logic serFall;
  logic parRise;

  always_comb begin
    serFall = prevSerStrobe && !serStrobe;
    parRise = parLoadN && !prevParLoadN;

    strobes.shiftEn    = !serStrobe && serClk && !prevSerClk;
    strobes.serLatch   = serFall;
    // A serial event in the same cycle wins over a parallel capture.
    strobes.parCapture = parRise && !serFall;

    if (serStrobe)      strobes.mode = MODE_SERLIVE;
    else if (!parLoadN) strobes.mode = MODE_PARLIVE;
    else                strobes.mode = MODE_HELD;
  end
endmodule

// File: rtl/divcfg_datapath.sv
module divcfg_datapath
  import divcfg_pkg::*;
#(
  parameter int M_MIN = 10,
  parameter int M_MAX = 28,
  parameter int RST_M = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterRst,
  input  ctrlStrobes_t       strobes,
  input  logic [M_W-1:0]     parM,
  input  logic [N_W-1:0]     parN,
  input  logic               serData,
  output logic [M_W-1:0]     divM,
  output logic [N_W-1:0]     divN,
  output logic [RATIO_W-1:0] divRatio,
  output logic [T_W-1:0]     testSel,
  output logic               outEnable,
  output logic               mOutOfRange
);
  localparam logic [M_W-1:0] LO_LIM = M_W'(M_MIN);
  localparam logic [M_W-1:0] HI_LIM = M_W'(M_MAX);
  localparam cfgWord_t DEF_WORD = '{test: '0, n: '0, m: M_W'(RST_M)};

  cfgWord_t shiftQ, heldQ, heldD, liveD, outQ;
  logic     oorQ, oeQ;

  // Shift register: entered at bit 0, so the first bit ends at the MSB.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftQ <= DEF_WORD;
    else if (strobes.shiftEn) shiftQ <= cfgWord_t'({shiftQ[SER_W-2:0], serData});
  end

  // Held setting: a serial latch beats a parallel capture.
  always_comb begin
    heldD = heldQ;
    if (strobes.serLatch) begin
      heldD = shiftQ;
    end else if (strobes.parCapture) begin
      heldD.n = parN;
      heldD.m = parM;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldQ <= DEF_WORD;
    else       heldQ <= heldD;
  end

  // Output source choice.
  always_comb begin
    unique case (strobes.mode)
      MODE_SERLIVE: liveD = shiftQ;
      MODE_PARLIVE: liveD = '{test: '0, n: parN, m: parM};
      default:      liveD = heldD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= DEF_WORD;
      oorQ <= (DEF_WORD.m < LO_LIM) || (DEF_WORD.m > HI_LIM);
      oeQ  <= 1'b0;
    end else begin
      outQ <= liveD;
      oorQ <= (liveD.m < LO_LIM) || (liveD.m > HI_LIM);
      oeQ  <= !masterRst;
    end
  end

  // One-hot ratio decode, one bit per code value.
  for (genvar k = 0; k < RATIO_W; k++) begin : g_ratio
    assign divRatio[k] = (outQ.n == N_W'(k));
  end

  assign divM        = outQ.m;
  assign divN        = outQ.n;
  assign testSel     = outQ.test;
  assign outEnable   = oeQ;
  assign mOutOfRange = oorQ;
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int M_MIN = 10,
  parameter int M_MAX = 28,
  parameter int RST_M = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterRst,
  input  logic               parLoadN,
  input  logic [M_W-1:0]     parM,
  input  logic [N_W-1:0]     parN,
  input  logic               serStrobe,
  input  logic               serClk,
  input  logic               serData,
  output logic [M_W-1:0]     divM,
  output logic [N_W-1:0]     divN,
  output logic [RATIO_W-1:0] divRatio,
  output logic [T_W-1:0]     testSel,
  output logic               outEnable,
  output logic               mOutOfRange
);
  ctrlStrobes_t strobes;

  divcfg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .parLoadN  (parLoadN),
    .serStrobe (serStrobe),
    .serClk    (serClk),
    .strobes   (strobes)
  );

  divcfg_datapath #(
    .M_MIN (M_MIN),
    .M_MAX (M_MAX),
    .RST_M (RST_M)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .masterRst   (masterRst),
    .strobes     (strobes),
    .parM        (parM),
    .parN        (parN),
    .serData     (serData),
    .divM        (divM),
    .divN        (divN),
    .divRatio    (divRatio),
    .testSel     (testSel),
    .outEnable   (outEnable),
    .mOutOfRange (mOutOfRange)
  );
endmodule

// File: rtl/divcfg_checker.sv
module divcfg_checker
  import divcfg_pkg::*;
#(
  parameter int M_MIN = 10,
  parameter int M_MAX = 28
) (
  input logic               clk,
  input logic               rstN,
  input logic               masterRst,
  input logic               parLoadN,
  input logic [M_W-1:0]     parM,
  input logic [N_W-1:0]     parN,
  input logic               serStrobe,
  input logic [M_W-1:0]     divM,
  input logic [N_W-1:0]     divN,
  input logic [RATIO_W-1:0] divRatio,
  input logic [T_W-1:0]     testSel,
  input logic               outEnable,
  input logic               mOutOfRange
);
  a_r7_oe_low: assert property (@(posedge clk) disable iff (!rstN)
    masterRst |=> !outEnable);

  a_r7_oe_high: assert property (@(posedge clk) disable iff (!rstN)
    !masterRst |=> outEnable);

  a_r1_par_live: assert property (@(posedge clk) disable iff (!rstN)
    (!serStrobe && !parLoadN) |=>
      (divM == $past(parM) && divN == $past(parN) && testSel == '0));

  a_r4_ser_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (serStrobe && $past(serStrobe)) |=>
      ($stable(divM) && $stable(divN) && $stable(testSel)));

  a_r2_held_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!serStrobe && parLoadN && $stable(serStrobe) && $stable(parLoadN)) |=>
      ($stable(divM) && $stable(divN) && $stable(testSel)));

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(divRatio) == 1);

  a_r9_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (!serStrobe && !parLoadN && parM >= M_W'(M_MIN) && parM <= M_W'(M_MAX))
      |=> !mOutOfRange);

  a_r9_out_range: assert property (@(posedge clk) disable iff (!rstN)
    (!serStrobe && !parLoadN && (parM < M_W'(M_MIN) || parM > M_W'(M_MAX)))
      |=> mOutOfRange);
endmodule

bind divcfg_loader divcfg_checker #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .masterRst   (masterRst),
  .parLoadN    (parLoadN),
  .parM        (parM),
  .parN        (parN),
  .serStrobe   (serStrobe),
  .divM        (divM),
  .divN        (divN),
  .divRatio    (divRatio),
  .testSel     (testSel),
  .outEnable   (outEnable),
  .mOutOfRange (mOutOfRange)
);

// File: tb/divcfg_loader_test.sv
`timescale 1ns/1ps
module divcfg_loader_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterRst = 1'b0;
  logic       parLoadN = 1'b1;
  logic [8:0] parM = 9'd0;
  logic [1:0] parN = 2'd0;
  logic       serStrobe = 1'b0;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic [8:0] divM;
  logic [1:0] divN;
  logic [3:0] divRatio;
  logic [1:0] testSel;
  logic       outEnable;
  logic       mOutOfRange;

  always #2.5 clk = ~clk;

  divcfg_loader uut (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .parLoadN(parLoadN),
    .parM(parM), .parN(parN), .serStrobe(serStrobe), .serClk(serClk),
    .serData(serData), .divM(divM), .divN(divN), .divRatio(divRatio),
    .testSel(testSel), .outEnable(outEnable), .mOutOfRange(mOutOfRange)
  );

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [3:0] ratio;
    logic [1:0] t;
    logic       oe;
    logic       oor;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;

  // Reference state kept from the requirements.
  logic        mPrevPl = 1'b1, mPrevSb = 1'b0, mPrevSc = 1'b0;
  logic [12:0] mShift = {4'b0000, 9'd10};
  logic [12:0] mHeld  = {4'b0000, 9'd10};

  task automatic step(input logic pl, input logic [8:0] m, input logic [1:0] n,
                      input logic sb, input logic sc, input logic sd,
                      input logic mr, input string tag);
    logic doShift, doLatch, doCap;
    logic [12:0] oldShift, src;
    expItem_t e;
    @(negedge clk);
    parLoadN = pl; parM = m; parN = n;
    serStrobe = sb; serClk = sc; serData = sd; masterRst = mr;
    doShift  = !sb && sc && !mPrevSc;
    doLatch  = !sb && mPrevSb;
    doCap    = pl && !mPrevPl;
    oldShift = mShift;
    if (doLatch)    mHeld = oldShift;
    else if (doCap) mHeld = {mHeld[12:11], n, m};
    if (doShift)    mShift = {mShift[11:0], sd};
    if (sb)       src = oldShift;
    else if (!pl) src = {2'b00, n, m};
    else          src = mHeld;
    e.m = src[8:0]; e.n = src[10:9]; e.t = src[12:11];
    e.ratio = 4'b0001 << src[10:9];
    e.oe = !mr;
    e.oor = (src[8:0] < 9'd10) || (src[8:0] > 9'd28);
    e.tag = tag;
    mPrevPl = pl; mPrevSb = sb; mPrevSc = sc;
    expQ.push_back(e);
  endtask

  task automatic shiftWord(input logic [12:0] w, input logic pl, input string tag);
    for (int i = 12; i >= 0; i--) begin
      step(pl, 9'd0, 2'd0, 1'b0, 1'b1, w[i], 1'b0, tag);
      step(pl, 9'd0, 2'd0, 1'b0, 1'b0, w[i], 1'b0, tag);
    end
  endtask

  // Monitor: compares each cycle's result against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        total++;
        if (divM !== e.m || divN !== e.n || divRatio !== e.ratio ||
            testSel !== e.t || outEnable !== e.oe || mOutOfRange !== e.oor) begin
          bad++;
          $display("FAIL %s: got m=%0d n=%0d ratio=%0d t=%0d oe=%0b oor=%0b exp m=%0d n=%0d ratio=%0d t=%0d oe=%0b oor=%0b",
                   e.tag, divM, divN, divRatio, testSel, outEnable, mOutOfRange,
                   e.m, e.n, e.ratio, e.t, e.oe, e.oor);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    total++;
    if (divM !== 9'd10 || divN !== 2'd0 || testSel !== 2'd0 ||
        outEnable !== 1'b0 || divRatio !== 4'd1) begin
      bad++;
      $display("FAIL R10: got m=%0d n=%0d t=%0d oe=%0b ratio=%0d exp m=10 n=0 t=0 oe=0 ratio=1",
               divM, divN, testSel, outEnable, divRatio);
    end
    // R1 transparency, R8 every code, R9 range edges
    step(1'b0, 9'd20,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b0, 9'd9,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 low");
    step(1'b0, 9'd10,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 min R8");
    step(1'b0, 9'd28,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R9 max R8");
    step(1'b0, 9'd29,  2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R9 high R8");
    step(1'b0, 9'd300, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 big R8");
    // R2 capture then ignore pins
    step(1'b0, 9'd25,  2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R2 setup");
    step(1'b1, 9'd25,  2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R2 capture");
    step(1'b1, 9'd5,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 ignore");
    step(1'b1, 9'd17,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 ignore");
    // R3 shift word T=10 N=01 M=12, held output unchanged while shifting
    shiftWord({2'b10, 2'b01, 9'd12}, 1'b1, "R3 shifting");
    // R4 strobe high shows fields; serial clock/data ignored
    step(1'b1, 9'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R3 present");
    step(1'b1, 9'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R4 ignore clk");
    step(1'b1, 9'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 ignore clk");
    step(1'b1, 9'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 ignore clk");
    // R11 strobe beats low parallel enable
    step(1'b0, 9'd7, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    step(1'b1, 9'd7, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    // R5 latch on strobe fall
    step(1'b1, 9'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 latch");
    step(1'b1, 9'd4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R5 kept");
    // R7 master reset only drops enable
    step(1'b1, 9'd4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, "R7 assert");
    step(1'b1, 9'd4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, "R7 hold");
    step(1'b1, 9'd4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R7 release");
    // R6 parallel capture keeps test bits, then serial overrides
    step(1'b0, 9'd15, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 par live");
    step(1'b1, 9'd15, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 capture keeps t");
    step(1'b1, 9'd15, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 held");
    shiftWord({2'b01, 2'b11, 9'd27}, 1'b1, "R6 shifting");
    step(1'b1, 9'd15, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 present");
    step(1'b1, 9'd15, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 serial wins");
    step(1'b1, 9'd15, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 serial kept");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule